// File: doc/BRIEF.md
# Packet-Mode Write Queue Switch Sequencer

This block sits on the write side of a buffer that holds several independent queues. It runs in packet mode. A data word carries two marker bits that tag the first and the last word of a packet. The block decides which queue each write cycle targets and whether the word is committed to storage. It also picks which queue's full status is shown at the port.

A change of queue is requested with a one-cycle strobe, and the new queue number is sampled in that same cycle. The old queue stays the target for that cycle and for the two cycles after it. The last of those three cycles is the filler slot: it must carry a word with no marker, which pads the end of the old queue. The full flag already reports the new queue during the filler slot, and writes reach the new queue from the third cycle after the request.

The block also watches the marker bits. A protocol error output goes high and stays high until reset in two cases: a marker is written in the filler slot, or a queue change is requested while a packet is still open.

Top module: `qsw_write_port`

## Requirements
- R1: After reset the target queue is 0, the protocol error output is low and no switch is in progress.
- R2: When `sw_req` is high while no switch is in progress, `sw_addr` is captured in that cycle. `tgt_q` keeps the old queue for that cycle and for the next two cycles.
- R3: In the request cycle and the cycle after it, `store_we` follows `wr_en_n`. The strobe is high when `wr_en_n` is low and the old queue has room. It is low when `wr_en_n` is high.
- R4: `full_n` shows the `q_full_n` bit of the active queue. In the second cycle after the request (the filler slot) it shows the bit of the newly captured queue.
- R5: From the third cycle after the request, `tgt_q` equals the captured queue. Writes go there when `wr_en_n` is low and that queue has room.
- R6: `store_we` is never high while the `q_full_n` bit of `tgt_q` is low. A high `q_full_n` bit means the queue has room.
- R7: A request that arrives during a switch already in progress is ignored. It changes neither the captured queue nor the timing of that switch.
- R8: If the filler slot has `wr_en_n` low and a word with a start marker (bit 34) or an end marker (bit 35) set, `proto_err` goes high from the next cycle. The same marker with `wr_en_n` high raises no error.
- R9: A packet is open after a committed word with the start marker, until a committed word with the end marker. A request while a packet is open raises `proto_err` from the next cycle, unless the request cycle itself commits the end marker.
- R10: Once high, `proto_err` stays high until reset.
- R11: Only committed words (`store_we` high) open or close a packet. A start-marked word blocked by a full queue or by `wr_en_n` high leaves no packet open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 1 | Queue change strobe, active high |
| sw_addr | input | QW | Queue number sampled with the strobe |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DW | Data word; bit DW-2 start marker, bit DW-1 end marker |
| q_full_n | input | NQ | Per-queue room flags from storage, low means full |
| tgt_q | output | QW | Queue addressed by this cycle's write |
| store_we | output | 1 | Write strobe into storage |
| store_data | output | DW | Word forwarded to storage |
| full_n | output | 1 | Full flag of the queue being reported, low means full |
| proto_err | output | 1 | Sticky protocol error |

## Verification
Some properties are checked by assertions on every cycle. These cover the three-cycle hold of the old target, the handover to the captured queue, the full flag switching in the filler slot, no strobe into a full queue, the fixed phase order and the error never dropping. Other behaviours only the scenarios can show. These include the exact strobe pattern for every old/new queue pair under every enable pattern and full map, and requests being ignored during a switch. They also include the marker rules: a filler-slot marker with enable high versus low, an end marker in the request cycle, and blocked start markers leaving no packet open.

// File: rtl/qsw_pkg.sv
package qsw_pkg;

    // Switch progress: OPEN = steady, HOLD = cycle after request, FILL = filler slot
    typedef enum logic [1:0] {
        PH_OPEN = 2'd0,
        PH_HOLD = 2'd1,
        PH_FILL = 2'd2
    } qsw_phase_e;

endpackage

// File: rtl/qsw_phase_ctl.sv
module qsw_phase_ctl
    import qsw_pkg::*;
#(
    parameter int NQ = 4,
    parameter int QW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [QW-1:0] addr,
    output qsw_phase_e    phase,
    output logic [QW-1:0] act_q,
    output logic [QW-1:0] pend_q,
    output logic          accept
);

    localparam logic [QW-1:0] QZERO = '0;

    typedef struct packed {
        qsw_phase_e    phase;
        logic [QW-1:0] act;
        logic [QW-1:0] pend;
    } ctl_state_t;

    ctl_state_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        case (st_q.phase)
            PH_OPEN: begin
                if (req) begin
                    accept     = 1'b1;
                    st_d.pend  = addr;
                    st_d.phase = PH_HOLD;
                end
            end
            PH_HOLD: st_d.phase = PH_FILL;
            PH_FILL: begin
                st_d.phase = PH_OPEN;
                st_d.act   = st_q.pend;
            end
            default: st_d.phase = PH_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_OPEN;
            st_q.act   <= QZERO;
            st_q.pend  <= QZERO;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase  = st_q.phase;
    assign act_q  = st_q.act;
    assign pend_q = st_q.pend;

    AST_HOLD_TO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_HOLD) |=> (st_q.phase == PH_FILL)); // R7

    AST_FILL_TO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_FILL) |=> (st_q.phase == PH_OPEN)); // R7

endmodule

// File: rtl/qsw_full_pick.sv
module qsw_full_pick #(
    parameter int NQ = 4,
    parameter int QW = 2
) (
    input  logic [NQ-1:0] flags,
    input  logic [QW-1:0] sel,
    output logic          room
);

    always_comb begin
        room = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            if (sel == QW'(i)) room = flags[i];
        end
    end

endmodule

// File: rtl/qsw_pkt_guard.sv
module qsw_pkt_guard #(
    parameter int DW = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic wr_act,
    input  logic sop,
    input  logic eop,
    input  logic sw_accept,
    input  logic fill_slot,
    output logic err
);

    typedef struct packed {
        logic in_pkt;
        logic err;
    } guard_state_t;

    guard_state_t g_q, g_d;
    logic         mid_switch;
    logic         fill_mark;

    always_comb begin
        g_d        = g_q;
        mid_switch = sw_accept && g_q.in_pkt && !(commit && eop);
        fill_mark  = fill_slot && wr_act && (sop || eop);
        if (commit) begin
            if (eop)      g_d.in_pkt = 1'b0;
            else if (sop) g_d.in_pkt = 1'b1;
        end
        g_d.err = g_q.err || mid_switch || fill_mark;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.in_pkt <= 1'b0;
            g_q.err    <= 1'b0;
        end else begin
            g_q <= g_d;
        end
    end

    assign err = g_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.err |=> g_q.err); // R10

endmodule

// File: rtl/qsw_write_port.sv
module qsw_write_port
    import qsw_pkg::*;
#(
    parameter int NQ = 4,
    parameter int QW = $clog2(NQ),
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_req,
    input  logic [QW-1:0] sw_addr,
    input  logic          wr_en_n,
    input  logic [DW-1:0] wr_data,
    input  logic [NQ-1:0] q_full_n,
    output logic [QW-1:0] tgt_q,
    output logic          store_we,
    output logic [DW-1:0] store_data,
    output logic          full_n,
    output logic          proto_err
);

    localparam int SOP_BIT = DW - 2;
    localparam int EOP_BIT = DW - 1;

    qsw_phase_e    phase;
    logic [QW-1:0] act_q;
    logic [QW-1:0] pend_q;
    logic          accept;
    logic          act_room;
    logic          pend_room;

    qsw_phase_ctl #(.NQ(NQ), .QW(QW)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (sw_req),
        .addr   (sw_addr),
        .phase  (phase),
        .act_q  (act_q),
        .pend_q (pend_q),
        .accept (accept)
    );

    qsw_full_pick #(.NQ(NQ), .QW(QW)) u_pick_act (
        .flags (q_full_n),
        .sel   (act_q),
        .room  (act_room)
    );

    qsw_full_pick #(.NQ(NQ), .QW(QW)) u_pick_pend (
        .flags (q_full_n),
        .sel   (pend_q),
        .room  (pend_room)
    );

    always_comb begin
        tgt_q      = act_q;
        store_we   = !wr_en_n && act_room;
        store_data = wr_data;
        full_n     = (phase == PH_FILL) ? pend_room : act_room;
    end

    qsw_pkt_guard #(.DW(DW)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (store_we),
        .wr_act    (!wr_en_n),
        .sop       (wr_data[SOP_BIT]),
        .eop       (wr_data[EOP_BIT]),
        .sw_accept (accept),
        .fill_slot (phase == PH_FILL),
        .err       (proto_err)
    );

    AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> q_full_n[tgt_q]); // R6

    AST_OLD_HOLD_C: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tgt_q == $past(tgt_q))); // R2

    AST_OLD_HOLD_D: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 (tgt_q == $past(tgt_q))); // R2

    AST_NEW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##2 (tgt_q == $past(sw_addr, 3))); // R5

    AST_FILL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 (full_n == q_full_n[$past(sw_addr, 2)])); // R4

endmodule

// File: tb/qsw_write_port_tb_top.sv
module qsw_write_port_tb_top;

    localparam int NQ = 4;
    localparam int QW = 2;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_req = 1'b0;
    logic [QW-1:0] sw_addr = '0;
    logic          wr_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [NQ-1:0] q_full_n = '1;
    logic [QW-1:0] tgt_q;
    logic          store_we;
    logic [DW-1:0] store_data;
    logic          full_n;
    logic          proto_err;

    int vectors = 0;
    int fails = 0;

    localparam logic [DW-1:0] SOPW = 36'h4_0000_0011;
    localparam logic [DW-1:0] EOPW = 36'h8_0000_0022;
    localparam logic [DW-1:0] MIDW = 36'h0_0000_0033;

    always #10 clk = ~clk;

    qsw_write_port #(.NQ(NQ), .QW(QW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_addr(sw_addr),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .q_full_n(q_full_n),
        .tgt_q(tgt_q), .store_we(store_we), .store_data(store_data),
        .full_n(full_n), .proto_err(proto_err)
    );

    task automatic step(input logic req, input logic [QW-1:0] addr, input logic wen,
                        input logic [DW-1:0] d, input logic [QW-1:0] etgt,
                        input logic efull, input string tag);
        logic ewe;
        sw_req = req; sw_addr = addr; wr_en_n = wen; wr_data = d;
        ewe = !wen && q_full_n[etgt];
        #5;
        vectors++;
        if (tgt_q !== etgt || store_we !== ewe || full_n !== efull || store_data !== d) begin
            fails++;
            $display("FAIL %s tgt=%0d exp %0d we=%b exp %b full_n=%b exp %b", tag,
                     tgt_q, etgt, store_we, ewe, full_n, efull);
        end
        @(negedge clk);
    endtask

    task automatic chk_err(input logic e, input string tag);
        vectors++;
        if (proto_err !== e) begin
            fails++;
            $display("FAIL %s proto_err=%b exp %b", tag, proto_err, e);
        end
    endtask

    // one full switch cur->nw; wp = enable pattern B,C,D,E; extra = requests during switch
    task automatic do_switch(input logic [QW-1:0] cur, input logic [QW-1:0] nw,
                             input logic [3:0] wp, input logic [DW-1:0] db,
                             input logic [DW-1:0] dd, input logic extra);
        step(1'b1, nw, wp[0], db, cur, q_full_n[cur], "R2_R3 request cycle");
        step(extra, ~nw, wp[1], MIDW, cur, q_full_n[cur], "R3_R7 hold cycle");
        step(extra, ~nw, wp[2], dd, cur, q_full_n[nw], "R4 filler slot");
        step(1'b0, '0, wp[3], MIDW, nw, q_full_n[nw], "R5_R6 new queue");
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sw_req = 1'b0; wr_en_n = 1'b1; wr_data = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        #5;
        chk_err(1'b0, "R1 reset error");
        @(negedge clk);
        step(1'b0, '0, 1'b0, MIDW, 2'd0, q_full_n[0], "R1 reset target");

        // sweep: every old/new pair, every enable pattern, varying full maps
        for (int i = 0; i < 256; i++) begin
            logic [QW-1:0] a;
            logic [QW-1:0] b;
            logic [QW-1:0] cur;
            cur = tgt_q;
            a = QW'((i % 16) / 4);
            b = QW'(i % 4);
            q_full_n = NQ'((i * 5 + 3) % 16);
            do_switch(cur, a, 4'((i / 16) ^ 4'h5), '0, '0, i[0]);
            do_switch(a, b, 4'(i / 16), '0, '0, i[1]);
        end
        chk_err(1'b0, "R7 sweep leaves no error");
        q_full_n = '1;

        // R8: marker in filler slot with enable high is harmless
        do_switch(tgt_q, 2'd1, 4'b0100, '0, EOPW, 1'b0);
        chk_err(1'b0, "R8 marker with enable high");
        // R8: marker with enable low flags error
        do_switch(2'd1, 2'd2, 4'b0000, '0, SOPW, 1'b0);
        chk_err(1'b1, "R8 start marker in filler");
        do_reset();
        #5; chk_err(1'b0, "R1 cleared by reset"); @(negedge clk);
        do_switch(2'd0, 2'd3, 4'b0000, '0, EOPW, 1'b0);
        chk_err(1'b1, "R8 end marker in filler");
        do_reset();

        // R9: switch in the middle of a packet
        step(1'b0, '0, 1'b0, SOPW, 2'd0, 1'b1, "R9 start word");
        step(1'b0, '0, 1'b0, MIDW, 2'd0, 1'b1, "R9 mid word");
        step(1'b1, 2'd2, 1'b1, '0, 2'd0, 1'b1, "R9 request mid packet");
        #5; chk_err(1'b1, "R9 mid-packet switch");
        @(negedge clk);
        step(1'b0, '0, 1'b1, '0, 2'd0, 1'b1, "R9 filler");
        step(1'b0, '0, 1'b1, '0, 2'd2, 1'b1, "R9 new queue");
        for (int k = 0; k < 5; k++) step(1'b0, '0, 1'b1, '0, 2'd2, 1'b1, "R10 idle");
        chk_err(1'b1, "R10 error stays high");
        do_reset();

        // R9: end marker committed in the request cycle is fine
        step(1'b0, '0, 1'b0, SOPW, 2'd0, 1'b1, "R9 start word b");
        step(1'b0, '0, 1'b0, MIDW, 2'd0, 1'b1, "R9 mid word b");
        do_switch(2'd0, 2'd1, 4'b0110, EOPW, '0, 1'b0);
        chk_err(1'b0, "R9 end in request cycle");

        // R11: blocked start marker leaves no open packet
        q_full_n = 4'b1101;
        step(1'b0, '0, 1'b0, SOPW, 2'd1, 1'b0, "R11 start into full queue");
        step(1'b0, '0, 1'b1, SOPW, 2'd1, 1'b0, "R11 start with enable high");
        do_switch(2'd1, 2'd0, 4'b1111, '0, '0, 1'b0);
        chk_err(1'b0, "R11 blocked start opens nothing");
        q_full_n = '1;

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule